// File: doc/BRIEF.md
# Sweep-Scaled Trigger Holdoff Gate

This block stops a sweep generator from re-arming too soon after a sweep finishes. While the sweep runs, an internal holdoff timer is held cleared. When the sweep ends and retrace begins, the timer advances once per clock-enable tick. It stops when it reaches a terminal count taken from the sweep-time code. Slower sweep settings produce proportionally longer holdoff, so the displayed trace keeps a steady repetition pattern and does not flicker when the sweep speed is changed.

Once the holdoff has expired, the first qualified trigger is forwarded to the sweep state controller as a single-cycle pulse. A qualified trigger is a rising edge on the trigger input while the trigger enable is high. Earlier triggers are dropped and are not remembered. After one pulse the gate stays closed until the next sweep has started and a new retrace holdoff has run out.

Top module: `sweep_holdoff_gate`

## Requirements
- R1: On any clock edge where `sweep_active` is 1, the holdoff count returns to 0 and the expired flag clears.
- R2: While `sweep_active` is 0, the count rises by exactly one on each edge where `tick_en` is 1 and stays unchanged where `tick_en` is 0.
- R3: The holdoff length is `BASE_TICKS * (time_sel + 1)` enabled ticks, where `time_sel` is read as an unsigned 4-bit number. The expired flag sets on the edge of the last such tick. With `tick_en` held at 1, a trigger edge seen at the edge that ends retrace cycle N is forwarded if N is greater than the holdoff length, and dropped if N equals it.
- R4: A trigger edge means `trig_in` is 1 at an edge and was 0 at the previous edge. If such an edge occurs while the flag is set, `trig_en` is 1 and `sweep_active` is 0, `trig_out` is 1 for exactly one cycle, starting after that edge.
- R5: When `trig_en` is 0, a trigger edge is not forwarded, even after expiry.
- R6: At most one pulse is forwarded per expiry. Later trigger edges in the same retrace are dropped. The gate reopens only after `sweep_active` has been 1 and a new holdoff has elapsed.
- R7: Trigger edges that arrive before expiry are dropped, not queued. A trigger held high across the expiry is not forwarded.
- R8: A synchronous active-high `rst` clears the count, the flag and the output. After reset, a full holdoff must elapse before any trigger passes.
- R9: A trigger edge that arrives while `sweep_active` is 1 is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock enable that paces the holdoff count |
| sweep_active | input | 1 | 1 during the sweep, 0 during retrace |
| time_sel | input | CODE_W | Sweep-time code that scales the holdoff |
| trig_in | input | 1 | Raw trigger; its rising edge is the event |
| trig_en | input | 1 | Trigger enable; 1 allows forwarding |
| trig_out | output | 1 | One-cycle trigger pulse to the sweep state controller |

## Verification
On every cycle, the assertions check the following properties. The count clears during the sweep. It advances only on enabled ticks. The expired flag stays set until the next sweep. Every output pulse has an expired flag, an enable and a fresh trigger edge behind it, and no two pulses come back to back. Only the bench's scenarios can show the exact holdoff length for each of the sixteen codes, including the boundary cycle where a trigger is one cycle too early. The same applies to dropping a held-high trigger and to the full holdoff that reset demands.

// File: rtl/holdoff_pkg.sv
`timescale 1ns/1ps
package holdoff_pkg;

  // Number of enabled ticks the holdoff lasts for a given sweep-time code.
  function automatic int unsigned holdoff_ticks(input int unsigned code,
                                                input int unsigned base);
    return base * (code + 1);
  endfunction

  // Counter width able to hold the longest holdoff for a code width.
  function automatic int unsigned count_width(input int unsigned code_w,
                                              input int unsigned base);
    return $clog2(holdoff_ticks((1 << code_w) - 1, base) + 1);
  endfunction

endpackage

// File: rtl/holdoff_timer.sv
`timescale 1ns/1ps
module holdoff_timer #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned BASE_TICKS = 4,
  parameter int unsigned CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              sweep_active,
  input  logic [CODE_W-1:0] time_sel,
  output logic [CNT_W-1:0]  cnt,
  output logic              done
);
  import holdoff_pkg::*;

  logic [CNT_W:0] term;
  logic [CNT_W:0] next_cnt;

  always_comb begin
    term     = (CNT_W+1)'(holdoff_ticks(int'(time_sel), BASE_TICKS));
    next_cnt = {1'b0, cnt} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || sweep_active) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (tick_en && !done) begin
      cnt <= next_cnt[CNT_W-1:0];
      if (next_cnt >= term) done <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_edge.sv
`timescale 1ns/1ps
module trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic rise
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_in;
  end

  assign rise = trig_in & ~trig_q;
endmodule

// File: rtl/trig_gate.sv
`timescale 1ns/1ps
module trig_gate (
  input  logic clk,
  input  logic rst,
  input  logic sweep_active,
  input  logic hold_done,
  input  logic trig_en,
  input  logic trig_rise,
  output logic fire,
  output logic fired,
  output logic trig_out
);
  assign fire = ~sweep_active & hold_done & ~fired & trig_en & trig_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      fired    <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      trig_out <= fire;
      if (sweep_active) fired <= 1'b0;
      else if (fire)    fired <= 1'b1;
    end
  end
endmodule

// File: rtl/sweep_holdoff_gate.sv
`timescale 1ns/1ps
module sweep_holdoff_gate #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned BASE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              sweep_active,
  input  logic [CODE_W-1:0] time_sel,
  input  logic              trig_in,
  input  logic              trig_en,
  output logic              trig_out
);
  import holdoff_pkg::*;

  localparam int unsigned CNT_W = count_width(CODE_W, BASE_TICKS);

  logic [CNT_W-1:0] hold_cnt;
  logic             hold_done;
  logic             trig_rise;
  logic             gate_fire;
  logic             gate_fired;

  holdoff_timer #(
    .CODE_W(CODE_W), .BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sweep_active(sweep_active),
    .time_sel(time_sel), .cnt(hold_cnt), .done(hold_done)
  );

  trig_edge u_edge (
    .clk(clk), .rst(rst), .trig_in(trig_in), .rise(trig_rise)
  );

  trig_gate u_gate (
    .clk(clk), .rst(rst), .sweep_active(sweep_active), .hold_done(hold_done),
    .trig_en(trig_en), .trig_rise(trig_rise), .fire(gate_fire),
    .fired(gate_fired), .trig_out(trig_out)
  );
endmodule

// File: rtl/sweep_holdoff_gate_chk.sv
`timescale 1ns/1ps
module sweep_holdoff_gate_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             sweep_active,
  input logic             trig_in,
  input logic             trig_en,
  input logic             trig_out,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             hold_done,
  input logic             gate_fire,
  input logic             gate_fired
);
  // R1
  sweep_clears_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_active |=> (hold_cnt == '0) && !hold_done);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sweep_active && !tick_en) |=> $stable(hold_cnt) && $stable(hold_done));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!sweep_active && tick_en && !hold_done) |=> hold_cnt == $past(hold_cnt) + 1'b1);

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_done && !sweep_active) |=> hold_done);

  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(hold_done) && $past(trig_in) && !$past(sweep_active));

  // R4
  fire_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    gate_fire |=> trig_out);

  // R5
  enable_needed_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(trig_en));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);

  // R6
  closed_after_chk: assert property (@(posedge clk) disable iff (rst)
    gate_fired |=> !trig_out);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (hold_cnt == '0) && !hold_done && !trig_out);
endmodule

bind sweep_holdoff_gate sweep_holdoff_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .sweep_active(sweep_active),
  .trig_in(trig_in), .trig_en(trig_en), .trig_out(trig_out),
  .hold_cnt(hold_cnt), .hold_done(hold_done), .gate_fire(gate_fire),
  .gate_fired(gate_fired)
);

// File: tb/sweep_holdoff_gate_tb.sv
`timescale 1ns/1ps
module sweep_holdoff_gate_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       sweep_active = 1'b1;
  logic [3:0] time_sel = 4'd0;
  logic       trig_in = 1'b0;
  logic       trig_en = 1'b1;
  logic       trig_out;

  int checks = 0;
  int fails  = 0;

  sweep_holdoff_gate #(.CODE_W(4), .BASE_TICKS(4)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sweep_active(sweep_active),
    .time_sel(time_sel), .trig_in(trig_in), .trig_en(trig_en),
    .trig_out(trig_out)
  );

  always #4 clk = ~clk;

  // Holdoff length restated as a shift: four ticks per code step.
  function automatic int span(input int code);
    return (code + 1) << 2;
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: trig_out=%0b expected %0b", req, got, exp);
    end
  endtask

  // Pulse trig_in for one cycle; check the forwarded pulse and its end.
  task automatic pulse(input logic exp, input string req);
    trig_in = 1'b1;
    @(negedge clk);
    check(trig_out, exp, req);
    trig_in = 1'b0;
    @(negedge clk);
    check(trig_out, 1'b0, req);
  endtask

  // Run a sweep, then start retrace and wait d cycles.
  task automatic start_retrace(input int code, input int d);
    sweep_active = 1'b1;
    time_sel = 4'(code);
    repeat (3) @(negedge clk);
    sweep_active = 1'b0;
    repeat (d) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(trig_out, 1'b0, "R8 reset state");
    rst = 1'b0;

    // R3 R4 R6 R7: every code, one cycle early, then on time, then repeated
    for (int c = 0; c < 16; c++) begin
      start_retrace(c, span(c) - 1);
      pulse(1'b0, "R7 early edge dropped");
      pulse(1'b1, "R4 forwarded after expiry");
      pulse(1'b0, "R6 second edge dropped");
      start_retrace(c, span(c));
      pulse(1'b1, "R3 exact holdoff length");
    end

    // R5: enable low blocks, then the next edge passes
    trig_en = 1'b0;
    start_retrace(2, 40);
    pulse(1'b0, "R5 enable low");
    trig_en = 1'b1;
    pulse(1'b1, "R5 enable high again");

    // R9: edges during the sweep are ignored
    sweep_active = 1'b1;
    repeat (5) @(negedge clk);
    pulse(1'b0, "R9 during sweep");

    // R7: trigger held high across expiry
    trig_in = 1'b1;
    start_retrace(1, 20);
    check(trig_out, 1'b0, "R7 held trigger");
    trig_in = 1'b0;
    @(negedge clk);
    check(trig_out, 1'b0, "R7 held trigger release");
    pulse(1'b1, "R7 fresh edge after hold");

    // R2: counting only on enabled ticks
    tick_en = 1'b0;
    start_retrace(0, 60);
    pulse(1'b0, "R2 no ticks no expiry");
    tick_en = 1'b1;
    repeat (span(0) - 1) @(negedge clk);
    tick_en = 1'b0;
    repeat (30) @(negedge clk);
    pulse(1'b0, "R2 one tick short");
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    pulse(1'b1, "R2 last tick expires");
    tick_en = 1'b1;

    // R8: reset after expiry demands a full new holdoff
    start_retrace(3, 70);
    rst = 1'b1;
    @(negedge clk);
    check(trig_out, 1'b0, "R8 output cleared");
    @(negedge clk);
    rst = 1'b0;
    repeat (span(3) - 1) @(negedge clk);
    pulse(1'b0, "R8 blocked until holdoff");
    pulse(1'b1, "R8 open after holdoff");

    // R1: sweep mid-retrace restarts the count
    start_retrace(2, span(2) - 4);
    sweep_active = 1'b1;
    @(negedge clk);
    sweep_active = 1'b0;
    repeat (span(2) - 1) @(negedge clk);
    pulse(1'b0, "R1 count restarted");
    pulse(1'b1, "R1 expiry after restart");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule